// File: doc/BRIEF.md
# Exception Entry Sequencer

This block applies every architectural state change a processor core makes when it enters a trap handler. A one-cycle `take_i` pulse carries a major and minor cause code, the PC of the trapping instruction, the instruction word, a TLB-refill flag and an interrupt line index. On the next clock edge the sequencer updates the mode fields, the saved-mode and return-address registers, the cause fields, the faulting-address and faulting-instruction registers and the debug flags. It also produces the handler PC. A bus error input takes precedence over the supplied cause and turns it into an address error. Which sub-code is used depends on whether the failed access was a fetch or a data access.

Three entry routes exist, and each uses its own save registers. The debug route applies to breakpoints and to interrupts taken while the core is already in debug state. The refill route applies to TLB-refill traps that are not interrupts. The normal route handles everything else. Handler addresses for the normal route are spaced by a programmable stride. The two handler base addresses, the stride selector and the mode fields are loaded through a small configuration write port. That port is also the only way to leave debug state.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is asserted, the outputs hold these values: privilege level 0, interrupt enable 0, direct-address mode 1, paging 0, both handler bases 0, stride selector 0, error flag 0, all debug flags 0, PC 0x1C000000.
- R2: Every accepted entry sets the privilege level to 0 and clears interrupt enable one cycle after `take_i`. Any saved copy of the privilege level and interrupt enable is taken from the values held before that entry.
- R3: A breakpoint (major 0x1A, minor 0) takes the debug route. It sets the debug-cause flag, writes 0xC into the debug code, saves the PC in the debug return register, sets debug state and jumps to the exception base + 0x480. The refill flag is ignored on this route.
- R4: An interrupt (major 0) taken while debug state is set behaves as follows. It sets the debug-interrupt flag, saves the PC in the debug return register and jumps to the exception base + 0x480. The normal cause fields, saved mode and return address stay unchanged.
- R5: The faulting-address register is loaded with the PC for majors 0xB, 0xC, 0xD, 0xE, 0xF, 0x10, 0x11 and 0x12. Every other cause leaves it unchanged.
- R6: The faulting-instruction register is loaded with the instruction word for every accepted cause except three: interrupts, major 3, and major 8 with minor 0.
- R7: A non-interrupt entry with the refill flag set outside the debug route does the following. It saves the privilege level and interrupt enable into the refill saved-mode fields, sets direct-address mode, clears paging, stores PC>>2 in the refill return register and jumps to the refill base. The normal cause fields, saved mode and return address stay unchanged.
- R8: A normal-route entry writes the major code (6 bits) and minor code (9 bits) into the cause fields. It also saves the privilege level and interrupt enable into the saved-mode fields and stores the PC as the return address.
- R9: The normal route computes its stride as 4<<VS, or 0 when VS is 0. A normal exception jumps to the exception base + major × stride. An interrupt jumps to the exception base + (64 + line index) × stride.
- R10: With `bus_fault_i` set, the cause becomes major 8. The minor code is 0 when `bus_fetch_i` is set and 1 otherwise, whatever `ecode_i` and `esub_i` carry.
- R11: Legal causes are: majors 0–7, 0xA–0x12 and 0x1A, each with minor 0, and major 8 with minor 0 or 1. Any other cause sets a sticky error flag and leaves all other state unchanged.
- R12: A configuration write without a simultaneous entry updates one item, chosen by `cfg_sel_i`. Selector 0 loads the exception base, 1 the refill base and 2 the stride selector (bits 2:0). Selector 3 loads the mode: bits 1:0 privilege, bit 2 interrupt enable, bit 3 direct-address, bit 4 paging. Selector 4 clears all three debug flags. A configuration write in the same cycle as `take_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| take_i | input | 1 | Entry request, one cycle per entry |
| ecode_i | input | 6 | Major cause code |
| esub_i | input | 9 | Minor cause code |
| bus_fault_i | input | 1 | Entry caused by a failed bus transaction |
| bus_fetch_i | input | 1 | Failed transaction was an instruction fetch |
| refill_i | input | 1 | Entry is a TLB refill |
| irq_vec_i | input | VEC_W | Interrupt line index |
| pc_i | input | XLEN | PC of the trapping instruction |
| insn_i | input | 32 | Fetched instruction word |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration item selector |
| cfg_wdata_i | input | XLEN | Configuration write data |
| pc_o | output | XLEN | Handler PC |
| plv_o | output | 2 | Current privilege level |
| ie_o | output | 1 | Current interrupt enable |
| da_o | output | 1 | Direct-address mode |
| pg_o | output | 1 | Paging enable |
| pplv_o | output | 2 | Saved privilege level, normal route |
| pie_o | output | 1 | Saved interrupt enable, normal route |
| rplv_o | output | 2 | Saved privilege level, refill route |
| rie_o | output | 1 | Saved interrupt enable, refill route |
| era_o | output | XLEN | Return address, normal route |
| rera_o | output | XLEN-2 | Return address >> 2, refill route |
| ecode_o | output | 6 | Recorded major cause |
| esub_o | output | 9 | Recorded minor cause |
| badv_o | output | XLEN | Faulting address |
| badi_o | output | 32 | Faulting instruction |
| dera_o | output | XLEN | Return address, debug route |
| dst_o | output | 1 | Debug state |
| dcl_o | output | 1 | Debug entry caused by breakpoint |
| dei_o | output | 1 | Debug entry caused by interrupt |
| dbg_code_o | output | 6 | Debug cause code |
| eentry_o | output | XLEN | Exception handler base |
| rentry_o | output | XLEN | Refill handler base |
| vs_o | output | 3 | Stride selector |
| err_o | output | 1 | Sticky unsupported-cause flag |

## Verification
The bench uses the defaults XLEN = 32 and VEC_W = 4. With these, every stride selector 0–7 combined with the highest interrupt slot (64 + 15) still fits the address width. This makes the largest handler offset, 79 × 512, reachable and checkable without wrap-around. The reference model keeps the whole architectural state and compares it every cycle, while random causes, refill flags and configuration writes are applied. As a result, the debug-state interactions and the unchanged-field rules of all three routes are covered by the same comparison.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    localparam int ECODE_W      = 6;
    localparam int ESUB_W       = 9;
    localparam int INSN_W       = 32;
    localparam int VS_W         = 3;
    localparam int EXT_INT_BASE = 64;
    localparam int DBG_ENTRY_OFS = 'h480;

    localparam logic [ECODE_W-1:0] DBG_CAUSE_CODE = 6'hC;

    // Major cause codes (positions decoded by neighbours)
    localparam logic [ECODE_W-1:0] EC_INT  = 6'h00;
    localparam logic [ECODE_W-1:0] EC_PIF  = 6'h03;
    localparam logic [ECODE_W-1:0] EC_PPI  = 6'h07;
    localparam logic [ECODE_W-1:0] EC_ADE  = 6'h08;
    localparam logic [ECODE_W-1:0] EC_BCE  = 6'h0A;
    localparam logic [ECODE_W-1:0] EC_SYS  = 6'h0B;
    localparam logic [ECODE_W-1:0] EC_BRK  = 6'h0C;
    localparam logic [ECODE_W-1:0] EC_INE  = 6'h0D;
    localparam logic [ECODE_W-1:0] EC_IPE  = 6'h0E;
    localparam logic [ECODE_W-1:0] EC_FPD  = 6'h0F;
    localparam logic [ECODE_W-1:0] EC_SXD  = 6'h10;
    localparam logic [ECODE_W-1:0] EC_ASXD = 6'h11;
    localparam logic [ECODE_W-1:0] EC_FPE  = 6'h12;
    localparam logic [ECODE_W-1:0] EC_DBP  = 6'h1A;

    localparam logic [ESUB_W-1:0] SUB_ADE_FETCH = 9'd0;
    localparam logic [ESUB_W-1:0] SUB_ADE_MEM   = 9'd1;

    typedef enum logic [1:0] {
        PATH_NORMAL = 2'd0,
        PATH_REFILL = 2'd1,
        PATH_DEBUG  = 2'd2
    } entry_path_e;

    typedef enum logic [2:0] {
        CFG_EBASE  = 3'd0,
        CFG_RBASE  = 3'd1,
        CFG_VSPACE = 3'd2,
        CFG_MODE   = 3'd3,
        CFG_DBGCLR = 3'd4
    } cfg_sel_e;

endpackage

// File: rtl/exc_cause_classify.sv
module exc_cause_classify
    import exc_seq_pkg::*;
(
    input  logic [ECODE_W-1:0] ecode_i,
    input  logic [ESUB_W-1:0]  esub_i,
    input  logic               bus_fault_i,
    input  logic               bus_fetch_i,
    input  logic               refill_i,
    input  logic               dbg_active_i,
    output logic [ECODE_W-1:0] major_o,
    output logic [ESUB_W-1:0]  sub_o,
    output logic               legal_o,
    output logic               is_int_o,
    output entry_path_e        path_o,
    output logic               upd_badv_o,
    output logic               upd_badi_o
);

    always_comb begin
        // Bus errors override the supplied cause
        major_o = bus_fault_i ? EC_ADE : ecode_i;
        if (bus_fault_i) begin
            sub_o = bus_fetch_i ? SUB_ADE_FETCH : SUB_ADE_MEM;
        end else begin
            sub_o = esub_i;
        end

        is_int_o = (major_o == EC_INT);

        if (major_o == EC_ADE) begin
            legal_o = (sub_o == SUB_ADE_FETCH) || (sub_o == SUB_ADE_MEM);
        end else if ((major_o <= EC_PPI) ||
                     ((major_o >= EC_BCE) && (major_o <= EC_FPE)) ||
                     (major_o == EC_DBP)) begin
            legal_o = (sub_o == '0);
        end else begin
            legal_o = 1'b0;
        end

        upd_badv_o = (major_o >= EC_SYS) && (major_o <= EC_FPE);

        upd_badi_o = !(is_int_o || (major_o == EC_PIF) ||
                       ((major_o == EC_ADE) && (sub_o == SUB_ADE_FETCH)));

        if ((major_o == EC_DBP) || (is_int_o && dbg_active_i)) begin
            path_o = PATH_DEBUG;
        end else if (refill_i && !is_int_o) begin
            path_o = PATH_REFILL;
        end else begin
            path_o = PATH_NORMAL;
        end
    end

endmodule

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
    import exc_seq_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int VEC_W = 4
) (
    input  logic [XLEN-1:0]    base_i,
    input  logic [VS_W-1:0]    vs_i,
    input  logic [ECODE_W-1:0] major_i,
    input  logic               is_int_i,
    input  logic [VEC_W-1:0]   vec_i,
    output logic [XLEN-1:0]    target_o
);

    localparam int IDX_RAW = $clog2(EXT_INT_BASE + (1 << VEC_W));
    localparam int IDX_W   = (IDX_RAW > ECODE_W) ? IDX_RAW : ECODE_W;

    logic [IDX_W-1:0] slot;
    logic [XLEN-1:0]  offset;

    always_comb begin
        if (is_int_i) begin
            slot = IDX_W'(EXT_INT_BASE) + IDX_W'(vec_i);
        end else begin
            slot = IDX_W'(major_i);
        end
        if (vs_i == '0) begin
            offset = '0;
        end else begin
            offset = XLEN'(slot) << (32'(vs_i) + 32'd2);
        end
        target_o = base_i + offset;
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_seq_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              VEC_W    = 4,
    parameter logic [XLEN-1:0] RESET_PC = XLEN'(32'h1C00_0000)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take_i,
    input  logic [ECODE_W-1:0]  ecode_i,
    input  logic [ESUB_W-1:0]   esub_i,
    input  logic                bus_fault_i,
    input  logic                bus_fetch_i,
    input  logic                refill_i,
    input  logic [VEC_W-1:0]    irq_vec_i,
    input  logic [XLEN-1:0]     pc_i,
    input  logic [INSN_W-1:0]   insn_i,
    input  logic                cfg_we_i,
    input  logic [2:0]          cfg_sel_i,
    input  logic [XLEN-1:0]     cfg_wdata_i,
    output logic [XLEN-1:0]     pc_o,
    output logic [1:0]          plv_o,
    output logic                ie_o,
    output logic                da_o,
    output logic                pg_o,
    output logic [1:0]          pplv_o,
    output logic                pie_o,
    output logic [1:0]          rplv_o,
    output logic                rie_o,
    output logic [XLEN-1:0]     era_o,
    output logic [XLEN-3:0]     rera_o,
    output logic [ECODE_W-1:0]  ecode_o,
    output logic [ESUB_W-1:0]   esub_o,
    output logic [XLEN-1:0]     badv_o,
    output logic [INSN_W-1:0]   badi_o,
    output logic [XLEN-1:0]     dera_o,
    output logic                dst_o,
    output logic                dcl_o,
    output logic                dei_o,
    output logic [ECODE_W-1:0]  dbg_code_o,
    output logic [XLEN-1:0]     eentry_o,
    output logic [XLEN-1:0]     rentry_o,
    output logic [VS_W-1:0]     vs_o,
    output logic                err_o
);

    typedef struct packed {
        logic [XLEN-1:0]    pc;
        logic [1:0]         plv;
        logic               ie;
        logic               da;
        logic               pg;
        logic [1:0]         pplv;
        logic               pie;
        logic [1:0]         rplv;
        logic               rie;
        logic [XLEN-1:0]    era;
        logic [XLEN-3:0]    rera;
        logic [ECODE_W-1:0] ecode;
        logic [ESUB_W-1:0]  esub;
        logic [XLEN-1:0]    badv;
        logic [INSN_W-1:0]  badi;
        logic [XLEN-1:0]    dera;
        logic               dst;
        logic               dcl;
        logic               dei;
        logic [ECODE_W-1:0] dcode;
        logic [XLEN-1:0]    ebase;
        logic [XLEN-1:0]    rbase;
        logic [VS_W-1:0]    vs;
        logic               err;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic [ECODE_W-1:0] cls_major;
    logic [ESUB_W-1:0]  cls_sub;
    logic               cls_ok;
    logic               cls_int;
    entry_path_e        cls_path;
    logic               cls_badv;
    logic               cls_badi;
    logic [XLEN-1:0]    vec_target;

    exc_cause_classify u_classify (
        .ecode_i      (ecode_i),
        .esub_i       (esub_i),
        .bus_fault_i  (bus_fault_i),
        .bus_fetch_i  (bus_fetch_i),
        .refill_i     (refill_i),
        .dbg_active_i (s_q.dst),
        .major_o      (cls_major),
        .sub_o        (cls_sub),
        .legal_o      (cls_ok),
        .is_int_o     (cls_int),
        .path_o       (cls_path),
        .upd_badv_o   (cls_badv),
        .upd_badi_o   (cls_badi)
    );

    exc_vector_calc #(
        .XLEN  (XLEN),
        .VEC_W (VEC_W)
    ) u_vector (
        .base_i   (s_q.ebase),
        .vs_i     (s_q.vs),
        .major_i  (cls_major),
        .is_int_i (cls_int),
        .vec_i    (irq_vec_i),
        .target_o (vec_target)
    );

    always_comb begin
        s_d = s_q;
        if (take_i) begin
            if (!cls_ok) begin
                s_d.err = 1'b1;
            end else begin
                if (cls_badv) begin
                    s_d.badv = pc_i;
                end
                if (cls_badi) begin
                    s_d.badi = insn_i;
                end
                unique case (cls_path)
                    PATH_DEBUG: begin
                        s_d.dera = pc_i;
                        s_d.dst  = 1'b1;
                        if (cls_int) begin
                            s_d.dei = 1'b1;
                        end else begin
                            s_d.dcl   = 1'b1;
                            s_d.dcode = DBG_CAUSE_CODE;
                        end
                        s_d.pc = s_q.ebase + XLEN'(DBG_ENTRY_OFS);
                    end
                    PATH_REFILL: begin
                        s_d.rplv = s_q.plv;
                        s_d.rie  = s_q.ie;
                        s_d.da   = 1'b1;
                        s_d.pg   = 1'b0;
                        s_d.rera = pc_i[XLEN-1:2];
                        s_d.pc   = s_q.rbase;
                    end
                    default: begin
                        s_d.ecode = cls_major;
                        s_d.esub  = cls_sub;
                        s_d.pplv  = s_q.plv;
                        s_d.pie   = s_q.ie;
                        s_d.era   = pc_i;
                        s_d.pc    = vec_target;
                    end
                endcase
                s_d.plv = 2'd0;
                s_d.ie  = 1'b0;
            end
        end else if (cfg_we_i) begin
            case (cfg_sel_i)
                CFG_EBASE:  s_d.ebase = cfg_wdata_i;
                CFG_RBASE:  s_d.rbase = cfg_wdata_i;
                CFG_VSPACE: s_d.vs    = cfg_wdata_i[VS_W-1:0];
                CFG_MODE: begin
                    s_d.plv = cfg_wdata_i[1:0];
                    s_d.ie  = cfg_wdata_i[2];
                    s_d.da  = cfg_wdata_i[3];
                    s_d.pg  = cfg_wdata_i[4];
                end
                CFG_DBGCLR: begin
                    s_d.dst = 1'b0;
                    s_d.dcl = 1'b0;
                    s_d.dei = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.pc <= RESET_PC;
            s_q.da <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign pc_o       = s_q.pc;
    assign plv_o      = s_q.plv;
    assign ie_o       = s_q.ie;
    assign da_o       = s_q.da;
    assign pg_o       = s_q.pg;
    assign pplv_o     = s_q.pplv;
    assign pie_o      = s_q.pie;
    assign rplv_o     = s_q.rplv;
    assign rie_o      = s_q.rie;
    assign era_o      = s_q.era;
    assign rera_o     = s_q.rera;
    assign ecode_o    = s_q.ecode;
    assign esub_o     = s_q.esub;
    assign badv_o     = s_q.badv;
    assign badi_o     = s_q.badi;
    assign dera_o     = s_q.dera;
    assign dst_o      = s_q.dst;
    assign dcl_o      = s_q.dcl;
    assign dei_o      = s_q.dei;
    assign dbg_code_o = s_q.dcode;
    assign eentry_o   = s_q.ebase;
    assign rentry_o   = s_q.rbase;
    assign vs_o       = s_q.vs;
    assign err_o      = s_q.err;

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk
    import exc_seq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            take_i,
    input logic            cfg_we_i,
    input logic            cls_ok,
    input logic            cls_int,
    input logic [1:0]      cls_path,
    input logic [XLEN-1:0] pc_o,
    input logic [1:0]      plv_o,
    input logic            ie_o,
    input logic            da_o,
    input logic            pg_o,
    input logic [XLEN-1:0] era_o,
    input logic            dst_o,
    input logic            dei_o,
    input logic [XLEN-1:0] eentry_o,
    input logic [XLEN-1:0] rentry_o,
    input logic [2:0]      vs_o,
    input logic            err_o
);

    a_r2_entry_clears_mode: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && cls_ok |=> (plv_o == 2'd0) && !ie_o);

    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    a_r11_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && !cls_ok |=> err_o && $stable(pc_o) && $stable(era_o) && $stable(plv_o));

    a_r3_debug_target: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && cls_ok && (cls_path == 2'(PATH_DEBUG))
        |=> dst_o && (pc_o == $past(eentry_o) + XLEN'(DBG_ENTRY_OFS)));

    a_r4_debug_interrupt: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && cls_ok && cls_int && dst_o |=> dei_o && dst_o);

    a_r7_refill_mode: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && cls_ok && (cls_path == 2'(PATH_REFILL))
        |=> da_o && !pg_o && (pc_o == $past(rentry_o)));

    a_r12_cfg_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && cfg_we_i |=> $stable(eentry_o) && $stable(rentry_o) && $stable(vs_o));

endmodule

bind exc_entry_seq exc_entry_seq_chk #(.XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_i   (take_i),
    .cfg_we_i (cfg_we_i),
    .cls_ok   (cls_ok),
    .cls_int  (cls_int),
    .cls_path (cls_path),
    .pc_o     (pc_o),
    .plv_o    (plv_o),
    .ie_o     (ie_o),
    .da_o     (da_o),
    .pg_o     (pg_o),
    .era_o    (era_o),
    .dst_o    (dst_o),
    .dei_o    (dei_o),
    .eentry_o (eentry_o),
    .rentry_o (rentry_o),
    .vs_o     (vs_o),
    .err_o    (err_o)
);

// File: tb/exc_entry_seq_bench.sv
`timescale 1ns/1ps
module exc_entry_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        take = 1'b0;
    logic [5:0]  ecode = '0;
    logic [8:0]  esub = '0;
    logic        bfault = 1'b0;
    logic        bfetch = 1'b0;
    logic        refill = 1'b0;
    logic [3:0]  vec = '0;
    logic [31:0] pc_in = '0;
    logic [31:0] insn = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_data = '0;

    logic [31:0] pc_o, era_o, badv_o, badi_o, dera_o, eentry_o, rentry_o;
    logic [29:0] rera_o;
    logic [1:0]  plv_o, pplv_o, rplv_o;
    logic        ie_o, da_o, pg_o, pie_o, rie_o, dst_o, dcl_o, dei_o, err_o;
    logic [5:0]  ecode_o, dbg_code_o;
    logic [8:0]  esub_o;
    logic [2:0]  vs_o;

    always #4 clk = ~clk;   // 125 MHz

    exc_entry_seq u_exc_entry_seq (
        .clk(clk), .rst_n(rst_n), .take_i(take), .ecode_i(ecode), .esub_i(esub),
        .bus_fault_i(bfault), .bus_fetch_i(bfetch), .refill_i(refill),
        .irq_vec_i(vec), .pc_i(pc_in), .insn_i(insn), .cfg_we_i(cfg_we),
        .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_data), .pc_o(pc_o), .plv_o(plv_o),
        .ie_o(ie_o), .da_o(da_o), .pg_o(pg_o), .pplv_o(pplv_o), .pie_o(pie_o),
        .rplv_o(rplv_o), .rie_o(rie_o), .era_o(era_o), .rera_o(rera_o),
        .ecode_o(ecode_o), .esub_o(esub_o), .badv_o(badv_o), .badi_o(badi_o),
        .dera_o(dera_o), .dst_o(dst_o), .dcl_o(dcl_o), .dei_o(dei_o),
        .dbg_code_o(dbg_code_o), .eentry_o(eentry_o), .rentry_o(rentry_o),
        .vs_o(vs_o), .err_o(err_o)
    );

    int tests = 0;
    int fails = 0;
    bit chk_on = 0;
    bit done = 0;

    // ---------------- reference model ----------------
    logic [31:0] m_pc, m_era, m_badv, m_badi, m_dera, m_eb, m_rb;
    logic [29:0] m_rera;
    logic [1:0]  m_plv, m_pplv, m_rplv;
    logic        m_ie, m_da, m_pg, m_pie, m_rie, m_dst, m_dcl, m_dei, m_err;
    logic [5:0]  m_ec, m_dcode;
    logic [8:0]  m_es;
    logic [2:0]  m_vs;

    task automatic m_reset();
        m_pc = 32'h1C00_0000; m_plv = 0; m_ie = 0; m_da = 1; m_pg = 0;
        m_pplv = 0; m_pie = 0; m_rplv = 0; m_rie = 0; m_era = 0; m_rera = 0;
        m_ec = 0; m_es = 0; m_badv = 0; m_badi = 0; m_dera = 0;
        m_dst = 0; m_dcl = 0; m_dei = 0; m_dcode = 0;
        m_eb = 0; m_rb = 0; m_vs = 0; m_err = 0;
    endtask

    function automatic bit legal_cause(int maj, int sub);
        if (maj == 8) return (sub == 0 || sub == 1);
        if (sub != 0) return 0;
        return (maj < 8) || (maj >= 10 && maj <= 18) || (maj == 26);
    endfunction

    initial m_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reset();
        end else if (take) begin
            int maj, sub, slot, stride;
            bit intr;
            maj = bfault ? 8 : int'(ecode);
            sub = bfault ? (bfetch ? 0 : 1) : int'(esub);
            if (!legal_cause(maj, sub)) begin
                m_err = 1;
            end else begin
                intr = (maj == 0);
                if (maj >= 11 && maj <= 18) m_badv = pc_in;
                if (!(intr || maj == 3 || (maj == 8 && sub == 0))) m_badi = insn;
                if (maj == 26 || (intr && m_dst)) begin
                    m_dera = pc_in; m_dst = 1;
                    if (intr) m_dei = 1;
                    else begin m_dcl = 1; m_dcode = 6'hC; end
                    m_pc = m_eb + 32'h480;
                end else if (refill && !intr) begin
                    m_rplv = m_plv; m_rie = m_ie; m_da = 1; m_pg = 0;
                    m_rera = pc_in[31:2]; m_pc = m_rb;
                end else begin
                    m_ec = 6'(maj); m_es = 9'(sub);
                    m_pplv = m_plv; m_pie = m_ie; m_era = pc_in;
                    stride = (m_vs == 0) ? 0 : (4 << m_vs);
                    slot = intr ? 64 + int'(vec) : maj;
                    m_pc = m_eb + 32'(slot * stride);
                end
                m_plv = 0; m_ie = 0;
            end
        end else if (cfg_we) begin
            case (cfg_sel)
                3'd0: m_eb = cfg_data;
                3'd1: m_rb = cfg_data;
                3'd2: m_vs = cfg_data[2:0];
                3'd3: begin m_plv = cfg_data[1:0]; m_ie = cfg_data[2];
                            m_da = cfg_data[3]; m_pg = cfg_data[4]; end
                3'd4: begin m_dst = 0; m_dcl = 0; m_dei = 0; end
                default: ;
            endcase
        end
    end

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            check("R9 pc", 64'(pc_o), 64'(m_pc));
            check("R2 plv", 64'(plv_o), 64'(m_plv));
            check("R2 ie", 64'(ie_o), 64'(m_ie));
            check("R7 da", 64'(da_o), 64'(m_da));
            check("R7 pg", 64'(pg_o), 64'(m_pg));
            check("R8 pplv", 64'(pplv_o), 64'(m_pplv));
            check("R8 pie", 64'(pie_o), 64'(m_pie));
            check("R7 rplv", 64'(rplv_o), 64'(m_rplv));
            check("R7 rie", 64'(rie_o), 64'(m_rie));
            check("R8 era", 64'(era_o), 64'(m_era));
            check("R7 rera", 64'(rera_o), 64'(m_rera));
            check("R8 ecode", 64'(ecode_o), 64'(m_ec));
            check("R8 esub", 64'(esub_o), 64'(m_es));
            check("R5 badv", 64'(badv_o), 64'(m_badv));
            check("R6 badi", 64'(badi_o), 64'(m_badi));
            check("R3 dera", 64'(dera_o), 64'(m_dera));
            check("R3 dst", 64'(dst_o), 64'(m_dst));
            check("R3 dcl", 64'(dcl_o), 64'(m_dcl));
            check("R4 dei", 64'(dei_o), 64'(m_dei));
            check("R3 dcode", 64'(dbg_code_o), 64'(m_dcode));
            check("R12 ebase", 64'(eentry_o), 64'(m_eb));
            check("R12 rbase", 64'(rentry_o), 64'(m_rb));
            check("R12 vs", 64'(vs_o), 64'(m_vs));
            check("R11 err", 64'(err_o), 64'(m_err));
        end
    end

    // ---------------- stimulus ----------------
    task automatic entry(input int c, input int s, input logic [31:0] p,
                         input logic [31:0] w, input bit rf, input int v,
                         input bit bf, input bit bfe);
        take = 1; ecode = 6'(c); esub = 9'(s); pc_in = p; insn = w;
        refill = rf; vec = 4'(v); bfault = bf; bfetch = bfe;
        @(negedge clk);
        take = 0; refill = 0; bfault = 0; bfetch = 0;
    endtask

    task automatic cfg(input int sel, input logic [31:0] d);
        cfg_we = 1; cfg_sel = 3'(sel); cfg_data = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int legal_majors[19] = '{0,1,2,3,4,5,6,7,8,10,11,12,13,14,15,16,17,18,26};
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 pc", 64'(pc_o), 64'h1C00_0000);
        check("R1 plv/ie/da/pg", 64'({plv_o, ie_o, da_o, pg_o}), 64'b00010);
        check("R1 bases", 64'({eentry_o, rentry_o, vs_o}), 64'd0);
        check("R1 err/dbg", 64'({err_o, dst_o, dcl_o, dei_o}), 64'd0);
        rst_n = 1;
        chk_on = 1;
        @(negedge clk);

        cfg(0, 32'h1000_0000);
        cfg(1, 32'h2000_0000);
        cfg(3, 32'h0000_0017);            // plv 3, ie 1, da 0, pg 1
        entry(11, 0, 32'h0000_0100, 32'hDEAD_0001, 0, 0, 0, 0);   // SYS, vs 0
        check("R9 stride zero", 64'(pc_o), 64'h1000_0000);
        check("R8 saved plv", 64'(pplv_o), 64'd3);

        cfg(2, 32'd1);
        cfg(3, 32'h0000_0006);
        entry(12, 0, 32'h0000_0200, 32'hDEAD_0002, 0, 0, 0, 0);   // BRK
        check("R9 major slot", 64'(pc_o), 64'h1000_0060);

        cfg(2, 32'd7);
        entry(0, 0, 32'h0000_0300, 32'hDEAD_0003, 0, 5, 0, 0);    // interrupt line 5
        check("R9 interrupt slot", 64'(pc_o), 64'h1000_8A00);
        check("R6 interrupt keeps badi", 64'(badi_o), 64'hDEAD_0002);

        entry(3, 0, 32'h0000_0400, 32'hDEAD_0004, 0, 0, 0, 0);    // fetch page invalid
        entry(20, 3, 32'h0000_0500, 32'hDEAD_0005, 0, 0, 1, 1);   // bus fault, fetch
        check("R10 fetch fault major", 64'(ecode_o), 64'd8);
        check("R10 fetch fault minor", 64'(esub_o), 64'd0);
        entry(11, 0, 32'h0000_0600, 32'hDEAD_0006, 0, 0, 1, 0);   // bus fault, data
        check("R10 data fault minor", 64'(esub_o), 64'd1);
        check("R6 data fault badi", 64'(badi_o), 64'hDEAD_0006);
        entry(1, 0, 32'h0000_0700, 32'hDEAD_0007, 0, 0, 0, 0);    // load page invalid

        cfg(3, 32'h0000_0017);
        entry(1, 0, 32'h0000_0804, 32'hDEAD_0008, 1, 0, 0, 0);    // refill
        check("R7 refill pc", 64'(pc_o), 64'h2000_0000);
        check("R7 refill ret", 64'(rera_o), 64'h0000_0201);
        entry(0, 0, 32'h0000_0900, 32'hDEAD_0009, 1, 2, 0, 0);    // interrupt ignores refill

        // R12: write collides with entry
        cfg_we = 1; cfg_sel = 3'd0; cfg_data = 32'hFFFF_0000;
        entry(13, 0, 32'h0000_0A00, 32'hDEAD_000A, 0, 0, 0, 0);
        cfg_we = 0;
        check("R12 collided write ignored", 64'(eentry_o), 64'h1000_0000);

        entry(26, 0, 32'h0000_0B00, 32'hDEAD_000B, 1, 0, 0, 0);   // breakpoint
        check("R3 debug pc", 64'(pc_o), 64'h1000_0480);
        entry(0, 0, 32'h0000_0C00, 32'hDEAD_000C, 0, 3, 0, 0);    // interrupt in debug
        check("R4 debug interrupt dera", 64'(dera_o), 64'h0000_0C00);
        cfg(4, 32'd0);
        entry(0, 0, 32'h0000_0D00, 32'hDEAD_000D, 0, 1, 0, 0);

        entry(19, 0, 32'h0000_0E00, 32'hDEAD_000E, 0, 0, 0, 0);   // unsupported
        check("R11 error raised", 64'(err_o), 64'd1);
        entry(11, 2, 32'h0000_0F00, 32'hDEAD_000F, 0, 0, 0, 0);   // bad minor

        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 2) begin
                cfg($urandom_range(0, 4), $urandom);
            end else if (r == 9) begin
                entry($urandom_range(0, 63), $urandom_range(0, 3), $urandom, $urandom,
                      1'($urandom_range(0, 1)), $urandom_range(0, 15), 0, 0);
            end else begin
                int mj;
                mj = legal_majors[$urandom_range(0, 18)];
                entry(mj, (mj == 8) ? $urandom_range(0, 1) : 0, $urandom, $urandom,
                      1'($urandom_range(0, 1)), $urandom_range(0, 15),
                      ($urandom_range(0, 7) == 0), 1'($urandom_range(0, 1)));
            end
        end

        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule